// File: doc/BRIEF.md
# LVDS Pixel Lane Formatter

This block turns a stream of 24-bit RGB pixels into 7-bit parallel symbols for LVDS data lanes. Each pixel arrives with horizontal sync, vertical sync and a data-enable flag. There are two channels, A and B, with four lanes each. In single-link operation only channel A is driven, with one symbol set per accepted beat. In dual-link operation the active pixels of a line are paired: the first pixel of each pair goes to channel A and the second to channel B, so one symbol set covers two pixels. Beats outside the active area carry no colour, but they still carry the sync states on both channels.

Four configuration pins are sampled only at the start of a frame, so a frame is never split between two formats:

- dual-link enable
- 24-bit output enable
- a per-channel bit that picks which bits of each colour go to the fourth lane

With 18-bit output the two low bits of each colour are dropped and the fourth lane is switched off in the lane-enable mask.

Both stream sides use valid/ready. The output holds one symbol set. While `out_valid` is high and `out_ready` is low, that set stays unchanged and no input beat is taken. An input beat is taken only when the output register is free or emptying in the same cycle. A beat's symbols therefore appear on the clock edge that accepts it. In dual-link operation they appear on the edge that accepts the second pixel of the pair. A line with an odd pixel count is closed by one extra cycle in which the input is held off.

Top module: `lvfmt_top`

## Requirements
- R1: After reset, `out_valid` is 0, both symbol buses are all zero, `lane_en` is 8'h07 (single link, 18-bit), and `in_ready` is 1.
- R2: Lanes 0 to 2 of a channel carry a 21-bit word. The word holds six bits of red at bits 5:0, green at 11:6 and blue at 17:12, HSYNC at bit 18, VSYNC at 19 and DE at 20. Lane k carries word bits 7k+6:7k and sits at bus bits 7k+6:7k, so lane 3 sits at bus bits 27:21.
- R3: With 24-bit output and the channel's format bit at 1, the six-bit fields are colour bits 7:2. Lane 3 carries {0, blue[1:0], green[1:0], red[1:0]}.
- R4: With 24-bit output and the channel's format bit at 0, the six-bit fields are colour bits 5:0. Lane 3 carries {0, blue[7:6], green[7:6], red[7:6]}.
- R5: The format bit of channel B affects only channel B, and the format bit of channel A affects only channel A.
- R6: With 18-bit output, the six-bit fields are colour bits 7:2 whatever the format bit is, and lane 3 is all zero.
- R7: `lane_en` bits 3:0 belong to channel A and bits 7:4 to channel B. A channel's nibble is 4'h7 for 18-bit output and 4'hF for 24-bit output. Channel B's nibble is 0 in single link.
- R8: On a beat with DE low, every colour bit on every lane is zero, while HSYNC, VSYNC and DE are still sent.
- R9: In single link, every accepted beat gives one symbol set, and channel B is all zero.
- R10: In dual link, the first DE-high beat of a pair goes to channel A and the second goes to channel B, giving one symbol set per pair. A DE-low beat gives its own set, with both channels blank and carrying its sync bits.
- R11: If a DE-low beat arrives while half a pair is held, `in_ready` stays low for that beat. One set is emitted with the held pixel on A and, on B, zero colour with the held pixel's HSYNC, VSYNC and DE. The DE-low beat is accepted afterwards.
- R12: The configuration pins are sampled only on an accepted beat whose VSYNC is 1 when the previous accepted beat's VSYNC was 0 (reset counts as 0). They apply from that beat on, and pin changes at any other time have no effect.
- R13: A beat accepted on a clock edge raises `out_valid` after that same edge. While `out_valid` is high and `out_ready` is low, the symbols stay stable and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| cfg_dual | input | 1 | 1 selects dual link |
| cfg_out24 | input | 1 | 1 selects 24-bit output, 0 selects 18-bit |
| cfg_lsb_a | input | 1 | Channel A lane-3 placement: 1 puts the low bits on lane 3, 0 puts the high bits there |
| cfg_lsb_b | input | 1 | Channel B lane-3 placement, same encoding as channel A |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat taken this cycle |
| in_rgb | input | 24 | Pixel colour: red 23:16, green 15:8, blue 7:0 |
| in_hs | input | 1 | Horizontal sync of the beat |
| in_vs | input | 1 | Vertical sync of the beat |
| in_de | input | 1 | Data enable of the beat |
| out_valid | output | 1 | Symbol set present |
| out_ready | input | 1 | Sink takes the symbol set |
| cha_sym | output | 28 | Channel A lane symbols, lane k at bits 7k+6:7k |
| chb_sym | output | 28 | Channel B lane symbols, same layout |
| lane_en | output | 8 | Lane enable mask, channel A in 3:0 and channel B in 7:4 |

## Verification
On every cycle the assertions check four things:

- the output stays stable under back-pressure and no beat is taken while the output is stalled;
- the lane mask is always one of the legal shapes;
- a disabled channel B and a disabled fourth lane carry only zeros;
- a DE-low symbol set carries no colour bits.

Other behaviour can only be shown by the bench's scenarios, where a transaction model predicts every symbol set:

- the bit placement of each format;
- the independence of the per-channel format bits;
- the A/B pairing and the padding of odd lines;
- the sampling of the configuration only at the rising edge of vertical sync.

// File: rtl/lvfmt_pkg.sv
package lvfmt_pkg;
  localparam int COLOR_W = 8;
  localparam int LANE_W  = 7;
  localparam int LANES   = 4;
  localparam int BASE_W  = (3 * LANE_W - 3) / 3;
  localparam int EXTRA_W = COLOR_W - BASE_W;
  localparam int SYM_W   = LANES * LANE_W;
  localparam int RGB_W   = 3 * COLOR_W;

  typedef struct packed {
    logic [RGB_W-1:0] rgb;
    logic             hs;
    logic             vs;
    logic             de;
  } pix_t;

  typedef struct packed {
    logic dual;
    logic out24;
    logic lsb_a;
    logic lsb_b;
  } cfg_t;
endpackage

// File: rtl/lvfmt_lane_map.sv
module lvfmt_lane_map
  import lvfmt_pkg::*;
(
  input  pix_t             pix,
  input  logic             out24,
  input  logic             lsb,
  output logic [SYM_W-1:0] sym
);
  localparam int PAD_W = LANE_W - 3 * EXTRA_W;

  logic [2:0][BASE_W-1:0]  base;
  logic [2:0][EXTRA_W-1:0] extra;

  // component 0 = red (top of rgb), 1 = green, 2 = blue
  for (genvar c = 0; c < 3; c++) begin : g_col
    logic [COLOR_W-1:0] col;
    assign col      = pix.de ? pix.rgb[(2-c)*COLOR_W +: COLOR_W] : '0;
    assign base[c]  = (!out24 || lsb) ? col[COLOR_W-1 -: BASE_W] : col[BASE_W-1:0];
    assign extra[c] = lsb ? col[EXTRA_W-1:0] : col[COLOR_W-1 -: EXTRA_W];
  end

  logic [3*LANE_W-1:0] word;
  logic [LANE_W-1:0]   lane_hi;

  assign word    = {pix.de, pix.vs, pix.hs, base[2], base[1], base[0]};
  assign lane_hi = out24 ? {{PAD_W{1'b0}}, extra[2], extra[1], extra[0]} : '0;
  assign sym     = {lane_hi, word};
endmodule

// File: rtl/lvfmt_cfg_gate.sv
module lvfmt_cfg_gate
  import lvfmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic vs,
  input  cfg_t cfg_in,
  output cfg_t cfg_eff,
  output cfg_t cfg_cur
);
  logic vs_prev;
  logic frame_start;

  assign frame_start = take && vs && !vs_prev;
  assign cfg_eff     = frame_start ? cfg_in : cfg_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_prev <= 1'b0;
      cfg_cur <= '0;
    end else begin
      if (take) vs_prev <= vs;
      if (frame_start) cfg_cur <= cfg_in;
    end
  end
endmodule

// File: rtl/lvfmt_pair.sv
module lvfmt_pair
  import lvfmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  pix_t in_pix,
  input  logic space,
  input  logic dual,
  output logic in_ready,
  output logic emit,
  output pix_t pix_a,
  output pix_t pix_b,
  output logic b_off
);
  logic pend;
  pix_t hold;
  logic wait_flush;
  logic fire;
  logic flush;

  assign wait_flush = pend && !in_pix.de;
  assign in_ready   = space && !wait_flush;
  assign fire       = in_valid && in_ready;
  assign flush      = in_valid && wait_flush && space;

  always_comb begin
    emit  = 1'b0;
    pix_a = in_pix;
    pix_b = in_pix;
    b_off = !dual;
    if (flush) begin
      emit     = 1'b1;
      pix_a    = hold;
      pix_b    = '0;
      pix_b.hs = hold.hs;
      pix_b.vs = hold.vs;
      pix_b.de = hold.de;
      b_off    = 1'b0;
    end else if (fire) begin
      if (!dual || !in_pix.de) begin
        emit = 1'b1;
      end else if (pend) begin
        emit  = 1'b1;
        pix_a = hold;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      hold <= '0;
    end else if (flush) begin
      pend <= 1'b0;
    end else if (fire && dual && in_pix.de) begin
      pend <= !pend;
      if (!pend) hold <= in_pix;
    end
  end
endmodule

// File: rtl/lvfmt_top.sv
module lvfmt_top
  import lvfmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_dual,
  input  logic               cfg_out24,
  input  logic               cfg_lsb_a,
  input  logic               cfg_lsb_b,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [RGB_W-1:0]   in_rgb,
  input  logic               in_hs,
  input  logic               in_vs,
  input  logic               in_de,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SYM_W-1:0]   cha_sym,
  output logic [SYM_W-1:0]   chb_sym,
  output logic [2*LANES-1:0] lane_en
);
  localparam logic [LANES-1:0] MASK_18 = {1'b0, {(LANES-1){1'b1}}};
  localparam logic [LANES-1:0] MASK_24 = {LANES{1'b1}};

  cfg_t cfg_pins, cfg_eff, cfg_cur;
  pix_t in_pix, pix_a, pix_b;
  logic space, fire, emit, b_off;
  logic [1:0][SYM_W-1:0] sym_nx;
  logic [LANES-1:0] chan_mask;

  assign cfg_pins = '{dual: cfg_dual, out24: cfg_out24, lsb_a: cfg_lsb_a, lsb_b: cfg_lsb_b};
  assign in_pix   = '{rgb: in_rgb, hs: in_hs, vs: in_vs, de: in_de};
  assign space    = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  lvfmt_cfg_gate u_cfg (
    .clk(clk), .rst_n(rst_n), .take(fire), .vs(in_vs),
    .cfg_in(cfg_pins), .cfg_eff(cfg_eff), .cfg_cur(cfg_cur)
  );

  lvfmt_pair u_pair (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .space(space), .dual(cfg_eff.dual), .in_ready(in_ready),
    .emit(emit), .pix_a(pix_a), .pix_b(pix_b), .b_off(b_off)
  );

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    pix_t             p;
    logic             lsb;
    logic [SYM_W-1:0] raw;
    assign p   = (ch == 0) ? pix_a : pix_b;
    assign lsb = (ch == 0) ? cfg_eff.lsb_a : cfg_eff.lsb_b;
    lvfmt_lane_map u_map (.pix(p), .out24(cfg_eff.out24), .lsb(lsb), .sym(raw));
    if (ch == 0) begin : g_a
      assign sym_nx[ch] = raw;
    end else begin : g_b
      assign sym_nx[ch] = b_off ? '0 : raw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cha_sym   <= '0;
      chb_sym   <= '0;
    end else if (space) begin
      out_valid <= emit;
      if (emit) begin
        cha_sym <= sym_nx[0];
        chb_sym <= sym_nx[1];
      end
    end
  end

  assign chan_mask = cfg_cur.out24 ? MASK_24 : MASK_18;
  assign lane_en   = {cfg_cur.dual ? chan_mask : {LANES{1'b0}}, chan_mask};
endmodule

// File: rtl/lvfmt_chk.sv
module lvfmt_chk
  import lvfmt_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [SYM_W-1:0]   cha_sym,
  input logic [SYM_W-1:0]   chb_sym,
  input logic [2*LANES-1:0] lane_en
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(cha_sym) && $stable(chb_sym)); // R13

  AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R13

  AST_BASE_LANES_ON: assert property (@(posedge clk) disable iff (!rst_n)
    &lane_en[LANES-2:0]); // R7

  AST_B_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en[2*LANES-1:LANES] == '0) || (lane_en[2*LANES-1:LANES] == lane_en[LANES-1:0])); // R7

  AST_B_IDLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !lane_en[LANES] |-> chb_sym == '0); // R9

  AST_LANE3_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !lane_en[LANES-1] |-> cha_sym[SYM_W-1 -: LANE_W] == '0); // R6

  AST_BLANK_NO_COLOR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cha_sym[3*LANE_W-1] |->
      (cha_sym[3*BASE_W-1:0] == '0) && (cha_sym[SYM_W-1 -: LANE_W] == '0)); // R8
endmodule

bind lvfmt_top lvfmt_chk u_chk (.*);

// File: tb/tb_lvfmt_top.sv
module tb_lvfmt_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cfg_dual = 0, cfg_out24 = 0, cfg_lsb_a = 0, cfg_lsb_b = 0;
  logic in_valid = 0, in_hs = 0, in_vs = 0, in_de = 0, out_ready = 0;
  logic [23:0] in_rgb = '0;
  logic in_ready, out_valid;
  logic [27:0] cha_sym, chb_sym;
  logic [7:0] lane_en;

  lvfmt_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_out24(cfg_out24),
    .cfg_lsb_a(cfg_lsb_a), .cfg_lsb_b(cfg_lsb_b), .in_valid(in_valid),
    .in_ready(in_ready), .in_rgb(in_rgb), .in_hs(in_hs), .in_vs(in_vs),
    .in_de(in_de), .out_valid(out_valid), .out_ready(out_ready),
    .cha_sym(cha_sym), .chb_sym(chb_sym), .lane_en(lane_en)
  );

  int n_chk = 0, n_bad = 0;
  bit stall = 0;
  bit last_acc = 0;

  typedef struct packed { logic [27:0] a; logic [27:0] b; logic [3:0] cfg; } exp_t;
  exp_t q[$];

  // model state; cfg bits: [3] dual, [2] out24, [1] lsb_a, [0] lsb_b
  logic [3:0]  m_cfg = 4'b0000;
  logic        m_vsp = 1'b0;
  logic        m_pend = 1'b0;
  logic [26:0] m_hold = '0; // {rgb, hs, vs, de}

  function automatic logic [27:0] f_map(logic [23:0] rgb, logic hs, logic vs, logic de,
                                        logic o24, logic lsb);
    logic [7:0] c [3];
    logic [5:0] s [3];
    logic [1:0] x [3];
    for (int i = 0; i < 3; i++) begin
      c[i] = de ? rgb[23-8*i -: 8] : 8'h00;
      s[i] = (!o24 || lsb) ? c[i][7:2] : c[i][5:0];
      x[i] = lsb ? c[i][1:0] : c[i][7:6];
    end
    return {(o24 ? {1'b0, x[2], x[1], x[0]} : 7'b0), de, vs, hs, s[2], s[1], s[0]};
  endfunction

  function automatic logic [7:0] f_mask(logic [3:0] cf);
    logic [3:0] n;
    n = cf[2] ? 4'hF : 4'h7;
    return {(cf[3] ? n : 4'h0), n};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sample();
    exp_t e;
    string t3, tb;
    bit space;
    chk(out_valid == (q.size() != 0), "R13 out_valid", out_valid, q.size() != 0);
    chk(lane_en == f_mask(m_cfg), "R7 lane_en", lane_en, f_mask(m_cfg));
    if (out_valid && !out_ready) chk(!in_ready, "R13 stalled in_ready", in_ready, 0);
    if (m_pend && in_valid && !in_de) chk(!in_ready, "R11 flush in_ready", in_ready, 0);
    if (out_valid && out_ready && q.size() > 0) begin
      e  = q.pop_front();
      t3 = e.cfg[2] ? (e.cfg[1] ? "R3 lane3 A" : "R4 lane3 A") : "R6 lane3 A";
      tb = !e.cfg[3] ? "R9 chan B" :
           ((e.cfg[2] && (e.cfg[1] != e.cfg[0])) ? "R5 chan B" : "R10 chan B");
      chk(cha_sym[20:0] == e.a[20:0], "R2 lanes0-2 A", cha_sym, e.a);
      chk(cha_sym[27:21] == e.a[27:21], t3, cha_sym, e.a);
      chk(chb_sym == e.b, tb, chb_sym, e.b);
      if (!e.a[20]) chk(cha_sym[17:0] == 18'h0, "R8 blank colour", cha_sym, 0);
    end
    space = !out_valid || out_ready;
    last_acc = in_valid && in_ready;
    if (last_acc) begin
      if (in_vs && !m_vsp) m_cfg = {cfg_dual, cfg_out24, cfg_lsb_a, cfg_lsb_b};
      m_vsp = in_vs;
      if (!m_cfg[3]) begin
        q.push_back({f_map(in_rgb, in_hs, in_vs, in_de, m_cfg[2], m_cfg[1]), 28'h0, m_cfg});
      end else if (!in_de) begin
        q.push_back({f_map(in_rgb, in_hs, in_vs, in_de, m_cfg[2], m_cfg[1]),
                     f_map(in_rgb, in_hs, in_vs, in_de, m_cfg[2], m_cfg[0]), m_cfg});
      end else if (!m_pend) begin
        m_pend = 1'b1;
        m_hold = {in_rgb, in_hs, in_vs, in_de};
      end else begin
        q.push_back({f_map(m_hold[26:3], m_hold[2], m_hold[1], m_hold[0], m_cfg[2], m_cfg[1]),
                     f_map(in_rgb, in_hs, in_vs, in_de, m_cfg[2], m_cfg[0]), m_cfg});
        m_pend = 1'b0;
      end
    end else if (m_pend && in_valid && !in_de && space) begin
      q.push_back({f_map(m_hold[26:3], m_hold[2], m_hold[1], m_hold[0], m_cfg[2], m_cfg[1]),
                   f_map(24'h0, m_hold[2], m_hold[1], m_hold[0], m_cfg[2], m_cfg[0]), m_cfg});
      m_pend = 1'b0;
    end
  endtask

  task automatic pick_ready();
    out_ready = stall ? (($urandom % 3) != 0) : 1'b1;
  endtask

  task automatic beat(logic [23:0] rgb, logic hs, logic vs, logic de);
    in_rgb = rgb; in_hs = hs; in_vs = vs; in_de = de; in_valid = 1'b1;
    forever begin
      pick_ready();
      #1;
      sample();
      if (last_acc) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0;
      pick_ready();
      #1;
      sample();
      @(negedge clk);
    end
  endtask

  task automatic frame(logic [3:0] cf, int lines, int width);
    {cfg_dual, cfg_out24, cfg_lsb_a, cfg_lsb_b} = cf;
    beat(24'h0, 0, 1, 0);
    beat(24'h0, 0, 1, 0);
    {cfg_dual, cfg_out24, cfg_lsb_a, cfg_lsb_b} = ~cf; // ignored until next frame (R12)
    beat(24'h0, 0, 0, 0);
    for (int l = 0; l < lines; l++) begin
      beat(24'h0, 1, 0, 0);
      beat(24'h0, 0, 0, 0);
      for (int p = 0; p < width; p++) begin
        beat(24'($urandom), 0, 0, 1);
        if (($urandom % 5) == 0) idle(1);
      end
      beat(24'h0, 0, 0, 0);
      beat(24'h0, 0, 0, 0);
      #1;
      chk(lane_en == f_mask(cf), "R12 cfg held mid-frame", lane_en, f_mask(cf));
      #1;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(lane_en == 8'h07, "R1 lane_en", lane_en, 8'h07);
    chk(cha_sym == 0 && chb_sym == 0, "R1 symbols", {cha_sym, chb_sym}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    @(negedge clk);
    // directed corner cases
    frame(4'b0000, 2, 4);   // R6 single 18-bit
    frame(4'b0010, 2, 3);   // R6 format bit ignored at 18-bit
    frame(4'b0110, 2, 4);   // R3 single, low bits on lane 3
    frame(4'b0100, 2, 4);   // R4 single, high bits on lane 3
    frame(4'b1000, 2, 5);   // R10 R11 dual 18-bit, odd line
    frame(4'b1111, 2, 6);   // R10 dual 24-bit
    frame(4'b1110, 2, 7);   // R5 mixed formats
    frame(4'b1101, 2, 1);   // R5 R11 single-pixel line
    stall = 1;
    for (int f = 0; f < 24; f++) frame(4'($urandom), 1 + ($urandom % 3), 1 + ($urandom % 9));
    stall = 0;
    idle(6);
    chk(q.size() == 0, "R13 drained", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule